// File: doc/BRIEF.md
# Packed Halfword Multiplier with Q15 Fractional Mode

This block multiplies two 32-bit operand words lane by lane. Each word holds two 16-bit halfword lanes (lane 0 in bits 15:0, lane 1 in bits 31:16), or four byte lanes in byte mode. A single start pulse launches one operation. One cycle later a registered 64-bit product bus appears, marked by a one-cycle valid strobe.

There are three operation families:
- **Widening.** Two full 32-bit products, signed or unsigned. The lanes can be paired straight or crossed.
- **Q15 fractional.** Each 32-bit signed product is shifted arithmetically right by 15 and clipped to a signed halfword. This mode also supports straight or crossed pairing.
- **Byte.** Four 16-bit products, one per byte lane.

A saturation in the fractional mode raises a one-cycle pulse that travels with the result. It also sets a sticky flag, which holds until an explicit clear.

A datapath uses the block as an execution unit for packed DSP arithmetic. The surrounding logic places the 64-bit bus into its destination registers.

Top module: `simd_hmul`

## Requirements
- R1: After synchronous reset, `prod_o`, `valid_o`, `sat_o` and `ovf_o` are all zero.
- R2: `valid_o` is high in exactly the cycle after a cycle with `start_i` high, and low otherwise.
- R3: Widening mode (`frac_i`=0, `byte_i`=0, `cross_i`=0) gives two 32-bit products. `prod_o[31:0]` = A[15:0]×B[15:0] and `prod_o[63:32]` = A[31:16]×B[31:16]. Operands are two's complement when `sgn_i`=1 and unsigned when `sgn_i`=0.
- R4: Crossed widening (`cross_i`=1) gives `prod_o[31:0]` = A[15:0]×B[31:16] and `prod_o[63:32]` = A[31:16]×B[15:0]. Signedness follows `sgn_i` as in R3.
- R5: Q15 mode (`frac_i`=1, `cross_i`=0) sets `prod_o[16k+15:16k]` to the signed product A.lane k × B.lane k shifted arithmetically right by 15 and saturated to [−32768, 32767], for k = 0, 1. `prod_o[63:32]` is zero, and `sgn_i` is ignored (operands are always signed).
- R6: Crossed Q15 (`frac_i`=1, `cross_i`=1) fills result lane 1 from A.lane1×B.lane0 and result lane 0 from A.lane0×B.lane1.
- R7: In Q15 mode only the pair −32768 × −32768 saturates. It yields 0x7FFF, and `sat_o` is high together with `valid_o` for that result.
- R8: Byte mode (`byte_i`=1, `frac_i`=0) sets halfword k of `prod_o` to the 16-bit product A[8k+7:8k]×B[8k+7:8k], for k = 0..3. Signedness follows `sgn_i`, and `cross_i` is ignored. `frac_i`=1 takes priority over `byte_i`.
- R9: `ovf_o` is set by any Q15 saturation and stays set until `ovf_clr_i`. If a saturation and a clear occur in the same cycle, the flag stays set.
- R10: Widening and byte operations never raise `sat_o` and never change `ovf_o`.
- R11: Without `start_i`, `prod_o` holds its last value whatever the operand and control inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch an operation on the current inputs |
| opa_i | input | 32 | Operand word A |
| opb_i | input | 32 | Operand word B |
| sgn_i | input | 1 | 1 = signed operands (widening and byte modes) |
| cross_i | input | 1 | 1 = pair opposite halfword lanes |
| frac_i | input | 1 | 1 = Q15 fractional mode |
| byte_i | input | 1 | 1 = four byte-lane products |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| prod_o | output | 64 | Registered product bus |
| valid_o | output | 1 | Result strobe, one cycle after start |
| sat_o | output | 1 | Q15 saturation pulse aligned with `valid_o` |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench targets several corner cases, each of which a faulty design would get visibly wrong:

- **−32768 × −32768 in both modes.** In widening mode the correct answer is 0x40000000. In Q15 mode it must clip to 0x7FFF; a missing clip wraps to 0x8000.
- **0xFFFF × 0xFFFF under both signedness settings.** This exposes a sign-extension mistake, which returns 1 where 0xFFFE0001 is expected, or the reverse.
- **Crossed pairing.** Asymmetric lane values are used, so a swapped or ignored cross select moves products into the wrong half.
- **Sticky flag and mode priority.** Byte and sign selects are driven during Q15 operations. Widening operations, clears, and a same-cycle set and clear are placed around a saturating operation. A design that honoured the wrong select, or let a clear or a widening operation disturb the flag, would show a different bus or flag value.

// File: rtl/simd_hmul_pkg.sv
package simd_hmul_pkg;

  typedef enum logic [1:0] {
    OP_WIDE = 2'd0,
    OP_BYTE = 2'd1,
    OP_FRAC = 2'd2
  } op_kind_e;

  // Fractional select dominates byte select, which dominates widening.
  function automatic op_kind_e decode_op(input logic frac, input logic byt);
    if (frac)     return OP_FRAC;
    else if (byt) return OP_BYTE;
    else          return OP_WIDE;
  endfunction

endpackage

// File: rtl/simd_hmul_lane.sv
// One lane multiplier: signed or unsigned W x W -> 2W product.
module simd_hmul_lane #(
  parameter int W = 16
) (
  input  logic           sgn_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int XW = W + 1;
  localparam int FW = 2 * XW;

  logic signed [XW-1:0] a_x;
  logic signed [XW-1:0] b_x;
  logic signed [FW-1:0] full;

  always_comb begin
    a_x  = {sgn_i & a_i[W-1], a_i};
    b_x  = {sgn_i & b_i[W-1], b_i};
    full = FW'(a_x) * FW'(b_x);
    p_o  = full[2*W-1:0];
  end
endmodule

// File: rtl/simd_hmul_qsat.sv
// Fractional rescale: signed 2W product >>> (W-1), clipped to W bits.
module simd_hmul_qsat #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] p_i,
  output logic [W-1:0]   q_o,
  output logic           sat_o
);
  localparam int SH = W - 1;

  logic signed [2*W-1:0] shifted;
  logic                  hi_clip;
  logic                  lo_clip;

  always_comb begin
    shifted = $signed(p_i) >>> SH;
    // Fits in W bits only when the top W+1 bits are all equal.
    hi_clip = !shifted[2*W-1] && (|shifted[2*W-2:W-1]);
    lo_clip =  shifted[2*W-1] && !(&shifted[2*W-2:W-1]);
    sat_o   = hi_clip | lo_clip;
    if (hi_clip)      q_o = {1'b0, {(W-1){1'b1}}};
    else if (lo_clip) q_o = {1'b1, {(W-1){1'b0}}};
    else              q_o = shifted[W-1:0];
  end
endmodule

// File: rtl/simd_hmul.sv
module simd_hmul #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [2*HW-1:0] opa_i,
  input  logic [2*HW-1:0] opb_i,
  input  logic          sgn_i,
  input  logic          cross_i,
  input  logic          frac_i,
  input  logic          byte_i,
  input  logic          ovf_clr_i,
  output logic [4*HW-1:0] prod_o,
  output logic          valid_o,
  output logic          sat_o,
  output logic          ovf_o
);
  import simd_hmul_pkg::*;

  localparam int NH  = 2;
  localparam int BW  = HW / 2;
  localparam int NB  = 2 * NH;
  localparam int PW  = 2 * HW;
  localparam int OW  = 4 * HW;

  op_kind_e          kind;
  logic              hsgn;
  logic [PW-1:0]     hprod [NH];
  logic [HW-1:0]     qres  [NH];
  logic [NH-1:0]     qsat;
  logic [HW-1:0]     bprod [NB];
  logic [OW-1:0]     nxt_prod;
  logic              nxt_sat;

  assign kind = decode_op(frac_i, byte_i);
  // Fractional products are always two's complement.
  assign hsgn = (kind == OP_FRAC) ? 1'b1 : sgn_i;

  // Halfword multipliers, shared by widening and Q15 modes.
  for (genvar k = 0; k < NH; k++) begin : g_half
    localparam int KX = NH - 1 - k;
    logic [HW-1:0] b_sel;
    assign b_sel = cross_i ? opb_i[KX*HW +: HW] : opb_i[k*HW +: HW];

    simd_hmul_lane #(.W(HW)) u_mul (
      .sgn_i (hsgn),
      .a_i   (opa_i[k*HW +: HW]),
      .b_i   (b_sel),
      .p_o   (hprod[k])
    );

    simd_hmul_qsat #(.W(HW)) u_qsat (
      .p_i   (hprod[k]),
      .q_o   (qres[k]),
      .sat_o (qsat[k])
    );
  end

  // Byte-lane multipliers for the four-product mode.
  for (genvar j = 0; j < NB; j++) begin : g_byte
    simd_hmul_lane #(.W(BW)) u_bmul (
      .sgn_i (sgn_i),
      .a_i   (opa_i[j*BW +: BW]),
      .b_i   (opb_i[j*BW +: BW]),
      .p_o   (bprod[j])
    );
  end

  always_comb begin
    nxt_prod = '0;
    nxt_sat  = 1'b0;
    unique case (kind)
      OP_FRAC: begin
        for (int k = 0; k < NH; k++) nxt_prod[k*HW +: HW] = qres[k];
        nxt_sat = |qsat;
      end
      OP_BYTE: begin
        for (int j = 0; j < NB; j++) nxt_prod[j*HW +: HW] = bprod[j];
      end
      default: begin
        for (int k = 0; k < NH; k++) nxt_prod[k*PW +: PW] = hprod[k];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_o  <= '0;
      valid_o <= 1'b0;
      sat_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= start_i;
      sat_o   <= start_i & nxt_sat;
      if (start_i) prod_o <= nxt_prod;
      if (start_i && nxt_sat) ovf_o <= 1'b1;
      else if (ovf_clr_i)     ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_hmul_chk.sv
module simd_hmul_chk #(
  parameter int HW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            frac_i,
  input logic            ovf_clr_i,
  input logic [4*HW-1:0] prod_o,
  input logic            valid_o,
  input logic            sat_o,
  input logic            ovf_o
);
  localparam logic [HW-1:0] QMAX = {1'b0, {(HW-1){1'b1}}};

  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> valid_o);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !valid_o);
  // R11
  hold_product_chk: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(prod_o));
  // R5
  frac_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && frac_i) |=> (prod_o[4*HW-1:2*HW] == '0));
  // R7
  sat_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    sat_o |-> (valid_o && (prod_o[HW-1:0] == QMAX || prod_o[2*HW-1:HW] == QMAX)));
  // R10
  no_sat_nonfrac_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !frac_i) |=> !sat_o);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  // R9
  ovf_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> sat_o);
endmodule

bind simd_hmul simd_hmul_chk #(.HW(HW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .frac_i    (frac_i),
  .ovf_clr_i (ovf_clr_i),
  .prod_o    (prod_o),
  .valid_o   (valid_o),
  .sat_o     (sat_o),
  .ovf_o     (ovf_o)
);

// File: tb/simd_hmul_bench.sv
module simd_hmul_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        sgn_i = 1'b0, cross_i = 1'b0, frac_i = 1'b0, byte_i = 1'b0;
  logic        ovf_clr_i = 1'b0;
  logic [63:0] prod_o;
  logic        valid_o, sat_o, ovf_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  simd_hmul u_simd_hmul (
    .clk(clk), .rst(rst), .start_i(start_i), .opa_i(opa_i), .opb_i(opb_i),
    .sgn_i(sgn_i), .cross_i(cross_i), .frac_i(frac_i), .byte_i(byte_i),
    .ovf_clr_i(ovf_clr_i), .prod_o(prod_o), .valid_o(valid_o),
    .sat_o(sat_o), .ovf_o(ovf_o)
  );

  // Control nibble: {frac, byte, cross, sgn}
  localparam int NV = 14;
  localparam logic [67:0] VEC [NV] = '{
    {4'b0000, 32'h0003_0002, 32'h0005_0007},  // R3 unsigned straight
    {4'b0001, 32'hFFFF_8000, 32'h0002_8000},  // R3 signed, -32768^2
    {4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R3 unsigned max
    {4'b0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R3 signed -1*-1
    {4'b0011, 32'h0003_FFFE, 32'h0005_0007},  // R4 signed crossed
    {4'b0010, 32'h0003_FFFE, 32'h0005_0007},  // R4 unsigned crossed
    {4'b1001, 32'hC000_4000, 32'h4000_4000},  // R5 Q15 straight
    {4'b1000, 32'h8001_7FFF, 32'h7FFF_7FFF},  // R5 sgn ignored
    {4'b1011, 32'h2000_4000, 32'hC000_1000},  // R6 Q15 crossed
    {4'b1001, 32'h1234_8000, 32'h4000_8000},  // R7 saturating lane 0
    {4'b1111, 32'h8000_0100, 32'h0100_8000},  // R6/R7/R8 crossed sat, byte ignored
    {4'b0101, 32'h80FF_7F03, 32'h80FF_7F05},  // R8 signed bytes
    {4'b0100, 32'h80FF_7F03, 32'h80FF_7F05},  // R8 unsigned bytes
    {4'b0111, 32'h0102_0304, 32'h0506_0708}   // R8 cross ignored
  };

  // Reference built from the requirement text: {sat, product}.
  function automatic logic [64:0] model(logic [3:0] c, logic [31:0] a, logic [31:0] b);
    logic [63:0] r = '0;
    logic        s = 1'b0;
    longint      x, y, p;
    if (c[3]) begin
      for (int k = 0; k < 2; k++) begin
        int kb = c[1] ? 1 - k : k;
        x = longint'($signed(a[16*k +: 16]));
        y = longint'($signed(b[16*kb +: 16]));
        p = (x * y) >>> 15;
        if (p > 32767)  begin p = 32767;  s = 1'b1; end
        if (p < -32768) begin p = -32768; s = 1'b1; end
        r[16*k +: 16] = p[15:0];
      end
    end else if (c[2]) begin
      for (int k = 0; k < 4; k++) begin
        x = c[0] ? longint'($signed(a[8*k +: 8])) : longint'(a[8*k +: 8]);
        y = c[0] ? longint'($signed(b[8*k +: 8])) : longint'(b[8*k +: 8]);
        p = x * y;
        r[16*k +: 16] = p[15:0];
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        int kb = c[1] ? 1 - k : k;
        x = c[0] ? longint'($signed(a[16*k +: 16]))  : longint'(a[16*k +: 16]);
        y = c[0] ? longint'($signed(b[16*kb +: 16])) : longint'(b[16*kb +: 16]);
        p = x * y;
        r[32*k +: 32] = p[31:0];
      end
    end
    return {s, r};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] c, logic [31:0] a, logic [31:0] b, logic clr);
    @(negedge clk);
    {frac_i, byte_i, cross_i, sgn_i} = c;
    opa_i = a; opb_i = b; start_i = 1'b1; ovf_clr_i = clr;
    @(negedge clk);
    start_i = 1'b0; ovf_clr_i = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); ovf_clr_i = 1'b1;
    @(negedge clk); ovf_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [64:0] e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", {prod_o[59:0], valid_o, sat_o, ovf_o, 1'b0}, 64'h0);
    check("R1 reset upper", {60'h0, prod_o[63:60]}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      pulse_clear();
      issue(VEC[i][67:64], VEC[i][63:32], VEC[i][31:0], 1'b0);
      e = model(VEC[i][67:64], VEC[i][63:32], VEC[i][31:0]);
      check($sformatf("R3-8 vec%0d product", i), prod_o, e[63:0]);
      check($sformatf("R2 vec%0d valid", i), {63'h0, valid_o}, 64'h1);
      check($sformatf("R7/R10 vec%0d sat", i), {63'h0, sat_o}, {63'h0, e[64]});
      check($sformatf("R9/R10 vec%0d ovf", i), {63'h0, ovf_o}, {63'h0, e[64]});
    end

    // Hand-worked values
    issue(4'b1001, 32'h8000_8000, 32'h8000_8000, 1'b0);
    check("R7 both lanes clip", prod_o, 64'h0000_0000_7FFF_7FFF);
    issue(4'b0001, 32'h0000_8000, 32'h0000_8000, 1'b0);
    check("R3 wide -32768^2", prod_o, 64'h0000_0000_4000_0000);
    @(negedge clk);
    check("R2 valid drops", {63'h0, valid_o}, 64'h0);
    check("R10 sat low after wide", {63'h0, sat_o}, 64'h0);

    // R11 hold: change inputs without start
    opa_i = 32'h1234_5678; opb_i = 32'h9ABC_DEF0; frac_i = 1'b0; byte_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 hold product", prod_o, 64'h0000_0000_4000_0000);

    // R9/R10 sticky behaviour
    check("R9 ovf still set", {63'h0, ovf_o}, 64'h1);
    issue(4'b0101, 32'h7F7F_7F7F, 32'h7F7F_7F7F, 1'b0);
    check("R10 byte op keeps ovf", {63'h0, ovf_o}, 64'h1);
    pulse_clear();
    check("R9 clear", {63'h0, ovf_o}, 64'h0);
    issue(4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    check("R10 wide op no ovf", {63'h0, ovf_o}, 64'h0);
    issue(4'b1000, 32'h0000_8000, 32'h0000_8000, 1'b1);
    check("R9 set beats clear", {63'h0, ovf_o}, 64'h1);
    check("R7 sat with clear", {63'h0, sat_o}, 64'h1);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 re-reset product", prod_o, 64'h0);
    check("R1 re-reset ovf", {63'h0, ovf_o}, 64'h0);

    done = 1'b1;
    finish_run();
  end
endmodule